// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit linear address that was not found in the translation cache. It walks a two-level table held in memory. The upper ten address bits select an entry in the page directory. The directory base comes from a control-register input, which the block samples when it accepts the request. A valid directory entry gives the base of a second-level table. The next ten address bits select the final entry in that table. The final entry supplies the frame number, and the low twelve bits of the address are carried through unchanged as the byte offset.

Each level costs one 32-bit read over a simple request/response port. A read request is held until the memory accepts it, and only one read is outstanding at a time. In each entry, bit 0 is the valid flag, bit 1 allows writes, bit 2 allows user access, and bits 31:12 hold the base of the next table or the frame.

A walk ends in one of two ways. It can finish with a translation, the combined permissions and a denied flag for the requested access type. Or it stops with a page fault that names the level whose entry was invalid. The block takes a new request only while it is idle.

Top module: `table_walker`

## Requirements
- R1: The first read of a walk goes to address {directory base bits 31:12, linear address bits 31:22, 2'b00}, using the directory base sampled at the request handshake.
- R2: After a valid directory entry, the second read goes to {directory entry bits 31:12, linear address bits 21:12, 2'b00}. A walk whose directory entry is invalid makes exactly one read.
- R3: A successful walk reports the physical address {final entry bits 31:12, linear address bits 11:0} and the frame number equal to final entry bits 31:12.
- R4: Entry bit 0 is the valid flag. An invalid directory entry ends the walk with doneFault=1 and faultLevel=0. An invalid final entry ends it with doneFault=1 and faultLevel=1. On a fault, donePaddr, doneFrame, donePerm and doneDenied are all zero.
- R5: donePerm[0] (write) is the AND of bit 1 of both entries. donePerm[1] (user) is the AND of bit 2 of both entries.
- R6: doneDenied is 1 on a successful walk when reqWrite was set and the write permission is 0, or when reqUser was set and the user permission is 0. Otherwise it is 0.
- R7: reqReady is high only while idle. A reqValid pulse during a walk is ignored and starts no read and no completion.
- R8: A change of dirBase after the request handshake does not affect the walk in progress. It does apply to the next request.
- R9: memReqValid stays high with an unchanged memReqAddr until memReqReady is seen. At most one read is outstanding.
- R10: After reset, reqReady=1, memReqValid=0 and doneValid=0. Each accepted request gives exactly one doneValid pulse, one cycle wide, in the cycle after the last needed read response. All result outputs are zero while doneValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Walk request strobe |
| reqReady | output | 1 | High while idle; a request is taken when both are high |
| reqAddr | input | 32 | Linear address to translate |
| reqWrite | input | 1 | Access is a write |
| reqUser | input | 1 | Access comes from user mode |
| dirBase | input | 32 | Page directory base control register (bits 31:12 used) |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 32 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Entry read from memory |
| doneValid | output | 1 | One-cycle walk completion strobe |
| doneFault | output | 1 | Walk ended on an invalid entry |
| faultLevel | output | 1 | 0: directory entry invalid, 1: final entry invalid |
| donePaddr | output | 32 | Translated physical address |
| doneFrame | output | 20 | Frame number |
| donePerm | output | 2 | Effective permissions {user, write} |
| doneDenied | output | 1 | Requested access not allowed by the permissions |

## Verification
A wrong state in the walker shows up at the memory port first. A wrong level or a wrong captured entry makes the second read address differ from {entry base, middle index, 00}, or changes the read count per walk. Both are visible within one read of the fault. A corrupted latched address or access type appears only at completion, as a wrong offset, frame, permission or denied flag. So every walk's results are compared at the doneValid cycle against a walk computed over the same sparse memory image. Control errors such as a skipped level or a second completion appear as extra or missing doneValid pulses, or as reqReady high during a walk. These are visible within a cycle of the transition.

// File: rtl/walk_pkg.sv
package walk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_DIR_ISSUE = 3'd1,
    ST_DIR_WAIT  = 3'd2,
    ST_PTE_ISSUE = 3'd3,
    ST_PTE_WAIT  = 3'd4,
    ST_DONE      = 3'd5,
    ST_FAULT     = 3'd6
  } walk_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;  // capture address, access type, directory base
    logic latchDir;  // capture directory entry
    logic latchPte;  // capture final entry
    logic usePte;    // memory address selects second level
    logic issue;     // a read request is being presented
    logic done;      // completion cycle
    logic fault;     // completion is a fault
  } walk_strobe_t;

endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         memReqReady,
  input  logic         memRspValid,
  input  logic         entryValid,
  output logic         reqReady,
  output logic         memReqValid,
  output logic         doneValid,
  output logic         doneFault,
  output logic         faultLevel,
  output walk_strobe_t strobe
);

  walk_state_t state, stateNext;
  logic        levelReg, levelNext;

  always_comb begin
    stateNext = state;
    levelNext = levelReg;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          stateNext       = ST_DIR_ISSUE;
        end
      end
      ST_DIR_ISSUE: begin
        strobe.issue = 1'b1;
        if (memReqReady) stateNext = ST_DIR_WAIT;
      end
      ST_DIR_WAIT: begin
        if (memRspValid) begin
          strobe.latchDir = 1'b1;
          if (entryValid) begin
            stateNext = ST_PTE_ISSUE;
          end else begin
            levelNext = 1'b0;
            stateNext = ST_FAULT;
          end
        end
      end
      ST_PTE_ISSUE: begin
        strobe.issue  = 1'b1;
        strobe.usePte = 1'b1;
        if (memReqReady) stateNext = ST_PTE_WAIT;
      end
      ST_PTE_WAIT: begin
        strobe.usePte = 1'b1;
        if (memRspValid) begin
          strobe.latchPte = 1'b1;
          if (entryValid) begin
            stateNext = ST_DONE;
          end else begin
            levelNext = 1'b1;
            stateNext = ST_FAULT;
          end
        end
      end
      ST_DONE: begin
        strobe.done = 1'b1;
        stateNext   = ST_IDLE;
      end
      ST_FAULT: begin
        strobe.done  = 1'b1;
        strobe.fault = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      levelReg <= 1'b0;
    end else begin
      state    <= stateNext;
      levelReg <= levelNext;
    end
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = strobe.issue;
  assign doneValid   = strobe.done;
  assign doneFault   = strobe.fault;
  assign faultLevel  = strobe.fault & levelReg;

  // R9: a presented read stays up until taken
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid);

  // R10: completion is a single-cycle pulse
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R7: an accepted request makes the block busy
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  // R7: no read is presented while idle
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReqValid && !doneValid);

endmodule

// File: rtl/walk_datapath.sv
module walk_datapath
  import walk_pkg::*;
#(
  parameter int AddrW = 32,
  parameter int IdxW  = 10,
  parameter int OffW  = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  walk_strobe_t            strobe,
  input  logic [AddrW-1:0]        reqAddr,
  input  logic                    reqWrite,
  input  logic                    reqUser,
  input  logic [AddrW-1:0]        dirBase,
  input  logic                    memReqReady,
  input  logic [AddrW-1:0]        memRspData,
  output logic                    entryValid,
  output logic [AddrW-1:0]        memReqAddr,
  output logic [AddrW-1:0]        donePaddr,
  output logic [AddrW-OffW-1:0]   doneFrame,
  output logic [1:0]              donePerm,
  output logic                    doneDenied
);

  localparam int FrameW = AddrW - OffW;
  localparam int PadW   = OffW - IdxW;   // entry alignment bits
  localparam int HiLsb  = OffW + IdxW;   // lsb of directory index

  logic [AddrW-1:0]  vaReg;
  logic              wrReg, usrReg;
  logic [FrameW-1:0] baseReg;
  logic [FrameW-1:0] dirNext;
  logic [1:0]        dirPerm;
  logic [FrameW-1:0] frameReg;
  logic [1:0]        ptePerm;
  logic [1:0]        effPerm;
  logic [IdxW-1:0]   dirIdx, pteIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaReg    <= '0;
      wrReg    <= 1'b0;
      usrReg   <= 1'b0;
      baseReg  <= '0;
      dirNext  <= '0;
      dirPerm  <= '0;
      frameReg <= '0;
      ptePerm  <= '0;
    end else begin
      if (strobe.latchReq) begin
        vaReg   <= reqAddr;
        wrReg   <= reqWrite;
        usrReg  <= reqUser;
        baseReg <= dirBase[AddrW-1:OffW];
      end
      if (strobe.latchDir) begin
        dirNext <= memRspData[AddrW-1:OffW];
        dirPerm <= memRspData[2:1];
      end
      if (strobe.latchPte) begin
        frameReg <= memRspData[AddrW-1:OffW];
        ptePerm  <= memRspData[2:1];
      end
    end
  end

  assign entryValid = memRspData[0];
  assign dirIdx     = vaReg[AddrW-1:HiLsb];
  assign pteIdx     = vaReg[HiLsb-1:OffW];

  always_comb begin
    if (strobe.usePte) memReqAddr = {dirNext, pteIdx, {PadW{1'b0}}};
    else               memReqAddr = {baseReg, dirIdx, {PadW{1'b0}}};
  end

  assign effPerm = dirPerm & ptePerm;

  always_comb begin
    donePaddr  = '0;
    doneFrame  = '0;
    donePerm   = '0;
    doneDenied = 1'b0;
    if (strobe.done && !strobe.fault) begin
      donePaddr  = {frameReg, vaReg[OffW-1:0]};
      doneFrame  = frameReg;
      donePerm   = effPerm;
      doneDenied = (wrReg && !effPerm[0]) || (usrReg && !effPerm[1]);
    end
  end

  logic unusedBits;
  assign unusedBits = ^{dirBase[OffW-1:0], memRspData[OffW-1:3]};

  // R9: the read address does not move while the request waits
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue && !memReqReady |=> $stable(memReqAddr));

  // R2: the second-level read base comes from the captured directory entry
  a_r2_second_base: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchDir |=> dirNext == $past(memRspData[AddrW-1:OffW]));

endmodule

// File: rtl/table_walker.sv
module table_walker
  import walk_pkg::*;
#(
  parameter int AddrW = 32,
  parameter int IdxW  = 10,
  parameter int OffW  = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [AddrW-1:0]      reqAddr,
  input  logic                  reqWrite,
  input  logic                  reqUser,
  input  logic [AddrW-1:0]      dirBase,
  output logic                  memReqValid,
  input  logic                  memReqReady,
  output logic [AddrW-1:0]      memReqAddr,
  input  logic                  memRspValid,
  input  logic [AddrW-1:0]      memRspData,
  output logic                  doneValid,
  output logic                  doneFault,
  output logic                  faultLevel,
  output logic [AddrW-1:0]      donePaddr,
  output logic [AddrW-OffW-1:0] doneFrame,
  output logic [1:0]            donePerm,
  output logic                  doneDenied
);

  walk_strobe_t strobe;
  logic         entryValid;

  walk_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .entryValid  (entryValid),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .doneValid   (doneValid),
    .doneFault   (doneFault),
    .faultLevel  (faultLevel),
    .strobe      (strobe)
  );

  walk_datapath #(.AddrW(AddrW), .IdxW(IdxW), .OffW(OffW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .reqWrite    (reqWrite),
    .reqUser     (reqUser),
    .dirBase     (dirBase),
    .memReqReady (memReqReady),
    .memRspData  (memRspData),
    .entryValid  (entryValid),
    .memReqAddr  (memReqAddr),
    .donePaddr   (donePaddr),
    .doneFrame   (doneFrame),
    .donePerm    (donePerm),
    .doneDenied  (doneDenied)
  );

endmodule

// File: tb/table_walker_test.sv
`timescale 1ns/1ps
module table_walker_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqUser = 1'b0;
  logic [31:0] dirBase = '0;
  logic        memReqValid;
  logic        memReqReady;
  logic [31:0] memReqAddr;
  logic        memRspValid;
  logic [31:0] memRspData;
  logic        doneValid, doneFault, faultLevel, doneDenied;
  logic [31:0] donePaddr;
  logic [19:0] doneFrame;
  logic [1:0]  donePerm;

  always #2 clk = ~clk;

  table_walker uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqUser(reqUser), .dirBase(dirBase),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .doneValid(doneValid),
    .doneFault(doneFault), .faultLevel(faultLevel), .donePaddr(donePaddr),
    .doneFrame(doneFrame), .donePerm(donePerm), .doneDenied(doneDenied)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // sparse memory image
  logic [31:0] mem [logic [31:0]];
  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory responder
  int          waitCfg = 0;
  int          latCfg = 1;
  int          waitLeft = 0;
  int          cd = 0;
  bit          holding = 0;
  logic [31:0] holdAddr = '0;
  logic [31:0] pendAddr = '0;
  int          stableErr = 0;
  int          logCount = 0;
  logic [31:0] logAddr [4];

  initial begin
    memReqReady = 1'b0;
    memRspValid = 1'b0;
    memRspData  = '0;
    forever begin
      @(negedge clk);
      if (memRspValid) memRspValid = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          memRspValid = 1'b1;
          memRspData  = rd(pendAddr);
        end
      end
      if (!memReqValid) begin
        memReqReady = 1'b0;
        holding     = 0;
      end else if (!memReqReady) begin
        if (!holding) begin
          holding  = 1;
          holdAddr = memReqAddr;
          waitLeft = waitCfg;
        end else if (memReqAddr !== holdAddr) begin
          stableErr++;
        end
        if (waitLeft > 0) waitLeft--;
        else begin
          memReqReady = 1'b1;
          if (logCount < 4) logAddr[logCount] = memReqAddr;
          logCount++;
          pendAddr = memReqAddr;
          cd       = latCfg;
        end
      end
    end
  end

  // reference walk from the requirements
  logic [31:0] eAddr0, eAddr1, ePaddr;
  logic [19:0] eFrame;
  logic [1:0]  ePerm;
  logic        eFault, eLevel, eDenied;
  int          eReads;

  task automatic refWalk(input logic [31:0] base, input logic [31:0] va, input logic w, input logic u);
    logic [31:0] de, pe;
    eAddr0 = {base[31:12], va[31:22], 2'b00};
    de     = rd(eAddr0);
    eAddr1 = {de[31:12], va[21:12], 2'b00};
    ePaddr = '0; eFrame = '0; ePerm = '0; eDenied = 1'b0; eLevel = 1'b0;
    if (!de[0]) begin
      eFault = 1'b1; eReads = 1;
    end else begin
      eReads = 2;
      pe     = rd(eAddr1);
      if (!pe[0]) begin
        eFault = 1'b1; eLevel = 1'b1;
      end else begin
        eFault  = 1'b0;
        ePaddr  = {pe[31:12], va[11:0]};
        eFrame  = pe[31:12];
        ePerm   = de[2:1] & pe[2:1];
        eDenied = (w && !ePerm[0]) || (u && !ePerm[1]);
      end
    end
  endtask

  // captured results
  logic [31:0] gPaddr;
  logic [19:0] gFrame;
  logic [1:0]  gPerm;
  logic        gFault, gLevel, gDenied, gGot;

  // mode 0 plain, 1 change dirBase after accept, 2 pulse reqValid mid-walk
  task automatic runWalk(input logic [31:0] va, input logic w, input logic u,
                         input int mode, input logic [31:0] altBase);
    int t;
    @(negedge clk);
    t = 0;
    while (!reqReady && t < 100) begin @(negedge clk); t++; end
    reqAddr = va; reqWrite = w; reqUser = u; reqValid = 1'b1;
    logCount = 0;
    @(negedge clk);
    reqValid = 1'b0;
    if (mode == 1) dirBase = altBase;
    if (mode == 2) begin
      reqAddr = 32'h1234_5678; reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
    end
    t = 0;
    while (!doneValid && t < 300) begin @(negedge clk); t++; end
    gGot = doneValid;
    gPaddr = donePaddr; gFrame = doneFrame; gPerm = donePerm;
    gFault = doneFault; gLevel = faultLevel; gDenied = doneDenied;
    if (!gGot) begin
      checks++; errors++;
      $display("FAIL R10 walk never completed actual=0 expected=1");
    end
    @(negedge clk);
    chk("R10 done pulse one cycle", {31'b0, doneValid}, 32'h0);
    chk("R10 results zero when idle", donePaddr | {12'b0, doneFrame}, 32'h0);
  endtask

  task automatic checkWalk(input string name, input logic [31:0] base, input logic [31:0] va,
                           input logic w, input logic u);
    refWalk(base, va, w, u);
    chk({name, " R1 first read addr"}, logAddr[0], eAddr0);
    chk({name, " R2 read count"}, logCount, eReads);
    if (eReads == 2) chk({name, " R2 second read addr"}, logAddr[1], eAddr1);
    chk({name, " R4 fault"}, {31'b0, gFault}, {31'b0, eFault});
    chk({name, " R4 fault level"}, {31'b0, gLevel}, {31'b0, eLevel});
    chk({name, " R3 paddr"}, gPaddr, ePaddr);
    chk({name, " R3 frame"}, {12'b0, gFrame}, {12'b0, eFrame});
    chk({name, " R5 perm"}, {30'b0, gPerm}, {30'b0, ePerm});
    chk({name, " R6 denied"}, {31'b0, gDenied}, {31'b0, eDenied});
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic        w;
    logic        u;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h0040_3ABC, 1'b0, 1'b1},   // full permissions
    '{32'h0040_5123, 1'b1, 1'b0},   // write allowed
    '{32'h0040_5FFF, 1'b0, 1'b1},   // user denied
    '{32'h0080_1000, 1'b1, 1'b0},   // directory grants nothing
    '{32'h00C0_0000, 1'b0, 1'b0},   // directory entry invalid
    '{32'h0040_7000, 1'b1, 1'b1},   // final entry invalid
    '{32'hFFFF_FFFF, 1'b1, 1'b1},   // top indices and offset
    '{32'h0000_0000, 1'b1, 1'b1}    // write-only dir, user-only page
  };

  localparam logic [31:0] BASE_A = 32'h0010_0000;
  localparam logic [31:0] BASE_B = 32'h0090_0000;

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mem[32'h0010_0004] = 32'h0020_0007;
    mem[32'h0020_000C] = 32'h0ABC_D007;
    mem[32'h0020_0014] = 32'h1234_5003;
    mem[32'h0010_0008] = 32'h0030_0001;
    mem[32'h0030_0004] = 32'h0055_5007;
    mem[32'h0010_0FFC] = 32'h00FF_F007;
    mem[32'h00FF_FFFC] = 32'hFFFF_F007;
    mem[32'h0010_0000] = 32'h0040_0003;
    mem[32'h0040_0000] = 32'h0001_0005;
    mem[32'h0090_0004] = 32'h0060_0007;
    mem[32'h0060_000C] = 32'h0777_7007;
    dirBase = BASE_A;

    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10 reset reqReady", {31'b0, reqReady}, 32'h1);
    chk("R10 reset memReqValid", {31'b0, memReqValid}, 32'h0);
    chk("R10 reset doneValid", {31'b0, doneValid}, 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 idle after reset", {30'b0, reqReady, memReqValid}, 32'h2);

    foreach (VECS[i]) begin
      latCfg = 1 + (i % 3);
      runWalk(VECS[i].va, VECS[i].w, VECS[i].u, 0, '0);
      checkWalk($sformatf("vec%0d", i), BASE_A, VECS[i].va, VECS[i].w, VECS[i].u);
    end

    // R9 stalled acceptance and long latency
    waitCfg = 3; latCfg = 4; stableErr = 0;
    runWalk(32'h0040_3ABC, 1'b1, 1'b1, 0, '0);
    checkWalk("stall", BASE_A, 32'h0040_3ABC, 1'b1, 1'b1);
    chk("R9 address stable while stalled", stableErr, 0);
    waitCfg = 0; latCfg = 1;

    // R8 base change during a walk has no effect, then applies
    runWalk(32'h0040_3ABC, 1'b0, 1'b0, 1, BASE_B);
    checkWalk("R8 mid-walk base", BASE_A, 32'h0040_3ABC, 1'b0, 1'b0);
    runWalk(32'h0040_3ABC, 1'b0, 1'b0, 0, '0);
    checkWalk("R8 next request base", BASE_B, 32'h0040_3ABC, 1'b0, 1'b0);
    chk("R8 new base paddr", gPaddr, 32'h0777_7ABC);
    dirBase = BASE_A;

    // R7 request while busy ignored
    runWalk(32'h0080_1000, 1'b0, 1'b1, 2, '0);
    checkWalk("R7 busy pulse", BASE_A, 32'h0080_1000, 1'b0, 1'b1);
    begin
      int extraDone = 0;
      int extraReq = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (doneValid) extraDone++;
        if (memReqValid) extraReq++;
      end
      chk("R7 no extra completion", extraDone, 0);
      chk("R7 no extra read", extraReq, 0);
      chk("R7 idle again", {31'b0, reqReady}, 32'h1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule